// File: doc/BRIEF.md
# Reader Argument Receiver with Acknowledge Waveform

This block sits behind the command decoder of a low-frequency transponder. Once a password-login or a selective-read command has been recognised, the receiver takes the argument bits that the reader sends next. It checks their parity structure bit by bit and then drives the antenna modulation with an acknowledge or a refusal pattern. It then holds off for a processing pause before it hands control back to the frame sequencer. A reset request follows a shorter path. It takes no argument bits: after a pause it tells the sequencer to reload its read window, answers with the acknowledge pattern, and waits an initialisation time.

All waveform and waiting durations are counted in carrier ticks (`tick`). A reception that breaks the format ends at the offending bit, and the refusal pattern starts at once. On a good selective read, the two captured word addresses come with a one-cycle load strobe for the sequencer.

Top module: `lf_arg_rx`

## Requirements
- R1: A login argument is 45 bits: four bytes, each sent MSB first and followed by its parity bit, then 8 column bits, then a 0. When it is accepted, `arg_ok` is 1 and `pwd` holds the first byte in bits 31:24, down to the last byte in bits 7:0.
- R2: Each byte-parity bit must equal the XOR of the 8 bits before it (even parity). A mismatch fails the reception at that parity bit.
- R3: The 8 column bits, MSB first, must equal the XOR of the four data bytes. A mismatch fails the reception at the eighth column bit.
- R4: The final bit of a login argument must be 0. A 1 fails the reception.
- R5: A selective-read argument is two 9-bit fields: 2 zero bits, a 6-bit address MSB first, then an even parity bit over the 8 bits before it. A set leading bit or a wrong parity fails the reception at that field's parity bit. On success, `addr_first` and `addr_last` hold the two addresses.
- R6: On a failure the receiver stops at once: `mod_out` is high two cycles after the offending bit is strobed. Later bits are ignored, and `arg_ok` stays 0.
- R7: The acknowledge pattern on `mod_out`, in ticks, is high 32, low 32, high 96, low 32, high 96, low 32.
- R8: The refusal pattern on `mod_out`, in ticks, is high 32, low 32, high 64, low 64, high 64, low 64.
- R9: `done` is a one-cycle pulse. It comes 64 ticks (plus at most 4 cycles) after the last segment of the response pattern ends.
- R10: `mode` 2 (reset) consumes no bits. It waits 64 ticks, pulses `rd_restore` as the acknowledge pattern starts, and raises `done` 2112 ticks after the pattern ends.
- R11: `sel_load` pulses together with `done` only after an accepted selective read (`mode` 1). Login (`mode` 0) never pulses it.
- R12: `start` clears `arg_ok`. It is set only by an accepted login or selective read, and it holds its value while the block is idle. After reset, `arg_ok`, `done`, `mod_out` and `sel_load` are 0.
- R13: A `start` with `mode` 3 is ignored: no modulation and no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation of kind `mode` (accepted when idle) |
| mode | input | 2 | 0 login, 1 selective read, 2 reset, 3 reserved |
| bit_vld | input | 1 | Strobe for one received argument bit |
| bit_in | input | 1 | Received argument bit |
| tick | input | 1 | One carrier period elapsed |
| pwd | output | 32 | Captured password |
| addr_first | output | 6 | Captured first word address |
| addr_last | output | 6 | Captured last word address |
| arg_ok | output | 1 | Argument accepted |
| sel_load | output | 1 | Load strobe for the selective-read range |
| rd_restore | output | 1 | Request to reload the read window after reset |
| mod_out | output | 1 | Antenna modulation |
| done | output | 1 | Operation finished |

## Verification
Streams built correctly for random passwords and address pairs must yield acknowledgements and the captured fields. Single-bit flips are then placed in data bits, parity bits, column bits and the closing zero. Each flip class has its own point of failure, so the bench can tell late detection from early detection and from the wrong check. An address field with a set leading bit but consistent parity separates the leading-zero check from the parity check. Timing of the reset path, with stray bits strobed during its pause, and the reserved mode round out the cases.

// File: rtl/lf_arg_rx_pkg.sv
package lf_arg_rx_pkg;

  typedef enum logic [1:0] {
    MODE_LOGIN = 2'd0,
    MODE_SELRD = 2'd1,
    MODE_RESET = 2'd2,
    MODE_NONE  = 2'd3
  } arg_mode_e;

  localparam int unsigned SEG_COUNT = 6;

  // even parity bit over one byte
  function automatic logic even_par8(input logic [7:0] b);
    return ^b;
  endfunction

  // duration in ticks of response segment idx; even segments are high
  function automatic int unsigned seg_len(input logic is_ack, input int unsigned idx,
                                          input int unsigned unit,
                                          input int unsigned ack_long,
                                          input int unsigned nack_long);
    int unsigned r;
    case (idx)
      0, 1:    r = unit;
      2, 4:    r = is_ack ? ack_long : nack_long;
      default: r = is_ack ? unit : (unit + ack_long - nack_long);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lf_arg_parser.sv
module lf_arg_parser
  import lf_arg_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        sel_mode,
  input  logic        bit_vld,
  input  logic        bit_in,
  output logic        fin,
  output logic        ok,
  output logic [31:0] pwd,
  output logic [5:0]  addr_a,
  output logic [5:0]  addr_b
);

  typedef enum logic [2:0] {P_IDLE, P_DATA, P_BPAR, P_CPAR, P_ZERO} pst_e;

  pst_e       pst;
  logic [2:0] bitcnt;
  logic [1:0] bytecnt;
  logic [7:0] cur;
  logic [7:0] colacc;
  logic [7:0] colrx;
  logic       second;
  logic [7:0] cur_nxt;
  logic [7:0] col_nxt;
  logic       bpar_bad;

  assign cur_nxt  = {cur[6:0], bit_in};
  assign col_nxt  = {colrx[6:0], bit_in};
  assign bpar_bad = (bit_in != even_par8(cur)) || (sel_mode && (cur[7:6] != 2'b00));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pst     <= P_IDLE;
      bitcnt  <= '0;
      bytecnt <= '0;
      cur     <= '0;
      colacc  <= '0;
      colrx   <= '0;
      second  <= 1'b0;
      fin     <= 1'b0;
      ok      <= 1'b0;
      pwd     <= '0;
      addr_a  <= '0;
      addr_b  <= '0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        pst     <= P_DATA;
        bitcnt  <= '0;
        bytecnt <= '0;
        colacc  <= '0;
        second  <= 1'b0;
        ok      <= 1'b0;
        pwd     <= '0;
        addr_a  <= '0;
        addr_b  <= '0;
      end else if (bit_vld) begin
        case (pst)
          P_DATA: begin
            cur    <= cur_nxt;
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) pst <= P_BPAR;
          end
          P_BPAR: begin
            if (bpar_bad) begin
              pst <= P_IDLE;
              fin <= 1'b1;
              ok  <= 1'b0;
            end else if (sel_mode) begin
              if (!second) begin
                addr_a <= cur[5:0];
                second <= 1'b1;
                pst    <= P_DATA;
              end else begin
                addr_b <= cur[5:0];
                pst    <= P_IDLE;
                fin    <= 1'b1;
                ok     <= 1'b1;
              end
            end else begin
              pwd     <= {pwd[23:0], cur};
              colacc  <= colacc ^ cur;
              bytecnt <= bytecnt + 2'd1;
              pst     <= (bytecnt == 2'd3) ? P_CPAR : P_DATA;
            end
          end
          P_CPAR: begin
            colrx  <= col_nxt;
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              if (col_nxt == colacc) begin
                pst <= P_ZERO;
              end else begin
                pst <= P_IDLE;
                fin <= 1'b1;
                ok  <= 1'b0;
              end
            end
          end
          P_ZERO: begin
            pst <= P_IDLE;
            fin <= 1'b1;
            ok  <= ~bit_in;
          end
          default: pst <= P_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/lf_resp_wave.sv
module lf_resp_wave
  import lf_arg_rx_pkg::*;
#(
  parameter int unsigned UNIT      = 32,
  parameter int unsigned ACK_LONG  = 96,
  parameter int unsigned NACK_LONG = 64,
  parameter int unsigned CNT_W     = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack,
  input  logic tick,
  output logic mod_out,
  output logic fin
);

  localparam int unsigned SEG_W = $clog2(SEG_COUNT);

  logic             act;
  logic             is_ack;
  logic [SEG_W-1:0] seg;
  logic [SEG_W-1:0] seg_nxt;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_last;

  assign seg_nxt  = seg + SEG_W'(1);
  assign cnt_last = CNT_W'(seg_len(is_ack, int'(seg), UNIT, ACK_LONG, NACK_LONG) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act     <= 1'b0;
      is_ack  <= 1'b0;
      seg     <= '0;
      cnt     <= '0;
      mod_out <= 1'b0;
      fin     <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        act     <= 1'b1;
        is_ack  <= ack;
        seg     <= '0;
        cnt     <= '0;
        mod_out <= 1'b1;
      end else if (act && tick) begin
        if (cnt == cnt_last) begin
          cnt <= '0;
          if (int'(seg) == SEG_COUNT - 1) begin
            act     <= 1'b0;
            mod_out <= 1'b0;
            fin     <= 1'b1;
          end else begin
            seg     <= seg_nxt;
            mod_out <= ~seg_nxt[0];
          end
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/lf_tick_wait.sv
module lf_tick_wait #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  input  logic             tick,
  output logic             fin
);

  logic             act;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0;
      cnt <= '0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        act <= 1'b1;
        cnt <= len;
      end else if (act && tick) begin
        if (cnt <= CNT_W'(1)) begin
          act <= 1'b0;
          fin <= 1'b1;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/lf_arg_rx.sv
module lf_arg_rx
  import lf_arg_rx_pkg::*;
#(
  parameter int unsigned UNIT        = 32,
  parameter int unsigned ACK_LONG    = 96,
  parameter int unsigned NACK_LONG   = 64,
  parameter int unsigned PAUSE_TICKS = 64,
  parameter int unsigned INIT_TICKS  = 2112
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  mode,
  input  logic        bit_vld,
  input  logic        bit_in,
  input  logic        tick,
  output logic [31:0] pwd,
  output logic [5:0]  addr_first,
  output logic [5:0]  addr_last,
  output logic        arg_ok,
  output logic        sel_load,
  output logic        rd_restore,
  output logic        mod_out,
  output logic        done
);

  localparam int unsigned CNT_W =
    $clog2(INIT_TICKS + PAUSE_TICKS + UNIT + ACK_LONG + NACK_LONG + 1);

  typedef enum logic [2:0] {T_IDLE, T_RX, T_PRE, T_WAVE, T_POST} tst_e;

  tst_e       tst;
  arg_mode_e  mode_q;

  // named internal events
  logic st_idle, st_rx, st_wave;
  logic rx_start, pre_start;
  logic rx_fin, rx_ok;
  logic wave_start, wave_ack, wave_fin;
  logic tmr_start, tmr_fin;
  logic [CNT_W-1:0] tmr_len;

  assign st_idle   = (tst == T_IDLE);
  assign st_rx     = (tst == T_RX);
  assign st_wave   = (tst == T_WAVE);
  assign rx_start  = st_idle && start &&
                     ((arg_mode_e'(mode) == MODE_LOGIN) || (arg_mode_e'(mode) == MODE_SELRD));
  assign pre_start = st_idle && start && (arg_mode_e'(mode) == MODE_RESET);

  assign wave_start = (st_rx && rx_fin) || ((tst == T_PRE) && tmr_fin);
  assign wave_ack   = (tst == T_PRE) ? 1'b1 : rx_ok;
  assign tmr_start  = pre_start || (st_wave && wave_fin);
  assign tmr_len    = (pre_start || (mode_q != MODE_RESET)) ? CNT_W'(PAUSE_TICKS)
                                                            : CNT_W'(INIT_TICKS);

  lf_arg_parser u_parse (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (rx_start),
    .sel_mode (mode_q == MODE_SELRD),
    .bit_vld  (bit_vld && st_rx),
    .bit_in   (bit_in),
    .fin      (rx_fin),
    .ok       (rx_ok),
    .pwd      (pwd),
    .addr_a   (addr_first),
    .addr_b   (addr_last)
  );

  lf_resp_wave #(
    .UNIT      (UNIT),
    .ACK_LONG  (ACK_LONG),
    .NACK_LONG (NACK_LONG),
    .CNT_W     (CNT_W)
  ) u_wave (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (wave_start),
    .ack     (wave_ack),
    .tick    (tick),
    .mod_out (mod_out),
    .fin     (wave_fin)
  );

  lf_tick_wait #(
    .CNT_W (CNT_W)
  ) u_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tmr_start),
    .len   (tmr_len),
    .tick  (tick),
    .fin   (tmr_fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tst        <= T_IDLE;
      mode_q     <= MODE_NONE;
      arg_ok     <= 1'b0;
      done       <= 1'b0;
      sel_load   <= 1'b0;
      rd_restore <= 1'b0;
    end else begin
      done       <= 1'b0;
      sel_load   <= 1'b0;
      rd_restore <= 1'b0;
      case (tst)
        T_IDLE: begin
          if (rx_start || pre_start) begin
            mode_q <= arg_mode_e'(mode);
            arg_ok <= 1'b0;
            tst    <= rx_start ? T_RX : T_PRE;
          end
        end
        T_RX: begin
          if (rx_fin) begin
            arg_ok <= rx_ok;
            tst    <= T_WAVE;
          end
        end
        T_PRE: begin
          if (tmr_fin) begin
            rd_restore <= 1'b1;
            tst        <= T_WAVE;
          end
        end
        T_WAVE: begin
          if (wave_fin) tst <= T_POST;
        end
        T_POST: begin
          if (tmr_fin) begin
            done     <= 1'b1;
            sel_load <= (mode_q == MODE_SELRD) && arg_ok;
            tst      <= T_IDLE;
          end
        end
        default: tst <= T_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lf_arg_rx_chk.sv
module lf_arg_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic done,
  input logic sel_load,
  input logic arg_ok,
  input logic rd_restore,
  input logic mod_out,
  input logic st_idle,
  input logic st_rx,
  input logic st_wave,
  input logic rx_fin
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_SEL_LOAD_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    sel_load |-> (done && arg_ok)); // R11

  AST_RESTORE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_restore |-> mod_out); // R10

  AST_QUIET_OUTSIDE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle || st_rx) |-> !mod_out); // R13

  AST_OK_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && !start) |=> $stable(arg_ok)); // R12

  AST_RESP_FOLLOWS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rx && rx_fin) |=> (st_wave && mod_out)); // R6

endmodule

bind lf_arg_rx lf_arg_rx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .done       (done),
  .sel_load   (sel_load),
  .arg_ok     (arg_ok),
  .rd_restore (rd_restore),
  .mod_out    (mod_out),
  .st_idle    (st_idle),
  .st_rx      (st_rx),
  .st_wave    (st_wave),
  .rx_fin     (rx_fin)
);

// File: tb/sim_lf_arg_rx.sv
`timescale 1ns/1ps
module sim_lf_arg_rx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        bit_vld = 1'b0;
  logic        bit_in = 1'b0;
  logic        tick = 1'b1;
  logic [31:0] pwd;
  logic [5:0]  addr_first, addr_last;
  logic        arg_ok, sel_load, rd_restore, mod_out, done;

  always #4 clk = ~clk;

  lf_arg_rx u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .bit_vld(bit_vld),
    .bit_in(bit_in), .tick(tick), .pwd(pwd), .addr_first(addr_first),
    .addr_last(addr_last), .arg_ok(arg_ok), .sel_load(sel_load),
    .rd_restore(rd_restore), .mod_out(mod_out), .done(done)
  );

  int n_chk = 0;
  int n_fail = 0;
  int txn = 0;

  // run-length monitor of mod_out, restarted on each new transaction
  int   seen_txn = 0;
  int   run = 0;
  int   rcnt = 0;
  int   rlen [0:15];
  int   done_gap = 0;
  int   ndone = 0;
  int   nsel = 0;
  int   nrest = 0;
  logic prev = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (txn != seen_txn) begin
        seen_txn = txn;
        run = 0; rcnt = 0; ndone = 0; nsel = 0; nrest = 0; done_gap = 0; prev = 1'b0;
      end
      if (mod_out !== prev) begin
        if (rcnt < 16) rlen[rcnt] = run;
        rcnt++;
        run = 1;
        prev = mod_out;
      end else begin
        run++;
      end
      if (done) begin ndone++; done_gap = run; end
      if (sel_load) nsel++;
      if (rd_restore) nrest++;
    end
  end

  task automatic chk(input bit good, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // bench-side parity: count ones
  function automatic bit odd_ones(input logic [7:0] b);
    int c = 0;
    for (int i = 0; i < 8; i++) if (b[i]) c++;
    return (c % 2) == 1;
  endfunction

  bit s [0:63];
  int n;

  task automatic push8(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin s[n] = b[i]; n++; end
  endtask

  task automatic build_login(input logic [31:0] p);
    logic [7:0] col = 8'h00;
    n = 0;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] by = p[31-8*k -: 8];
      push8(by);
      s[n] = odd_ones(by); n++;
      col = col ^ by;
    end
    push8(col);
    s[n] = 1'b0; n++;
  endtask

  task automatic build_sel(input logic [7:0] f1, input logic [7:0] f2);
    n = 0;
    push8(f1); s[n] = odd_ones(f1); n++;
    push8(f2); s[n] = odd_ones(f2); n++;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (ndone == 0 && t < 6000) begin @(negedge clk); t++; end
    chk(ndone == 1, req, "done pulse count", ndone, 1);
  endtask

  task automatic chk_wave(input bit ack, input int post, input string req);
    int lng = ack ? 96 : 64;
    int lo  = ack ? 32 : 64;
    chk(rcnt == 6, req, "mod_out edge count", rcnt, 6);
    chk(rlen[1] == 32 && rlen[2] == 32, req, "first high/low", rlen[1]*1000 + rlen[2], 32032);
    chk(rlen[3] == lng, req, "second high", rlen[3], lng);
    chk(rlen[4] == lo,  req, "second low", rlen[4], lo);
    chk(rlen[5] == lng, req, "third high", rlen[5], lng);
    chk(done_gap >= lo + post && done_gap <= lo + post + 4, "R9",
        "last fall to done", done_gap, lo + post);
  endtask

  // kind: 0 none, 1 flip bit k, 2 set top bit of first address with consistent parity
  task automatic run_args(input bit selm, input logic [31:0] p, input logic [5:0] a1,
                          input logic [5:0] a2, input int kind, input int k);
    int    fidx = -1;
    string freq;
    logic [7:0] f1 = {2'b00, a1};
    if (kind == 2) f1 = f1 | 8'h80;
    if (selm) build_sel(f1, {2'b00, a2}); else build_login(p);
    if (kind == 1) begin
      s[k] = ~s[k];
      if (selm) begin fidx = (k / 9) * 9 + 8; freq = "R5"; end
      else if (k < 36) begin fidx = (k / 9) * 9 + 8; freq = "R2"; end
      else if (k < 44) begin fidx = 43; freq = "R3"; end
      else begin fidx = 44; freq = "R4"; end
    end else if (kind == 2) begin
      fidx = 8; freq = "R5";
    end
    @(posedge clk); #1;
    txn++; start = 1'b1; mode = selm ? 2'd1 : 2'd0;
    @(posedge clk); #1;
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      bit_vld = 1'b1; bit_in = s[i];
      @(posedge clk); #1;
      bit_vld = 1'b0;
      @(posedge clk); #1;
      if (i == fidx) chk(mod_out == 1'b1, "R6", "refusal started after bad bit", mod_out, 1);
    end
    wait_done("R9");
    if (fidx < 0) begin
      chk(arg_ok == 1'b1, selm ? "R5" : "R1", "arg_ok on good stream", arg_ok, 1);
      if (selm) begin
        chk(addr_first == a1, "R5", "addr_first", addr_first, a1);
        chk(addr_last == a2, "R5", "addr_last", addr_last, a2);
        chk(nsel == 1, "R11", "sel_load pulses", nsel, 1);
      end else begin
        chk(pwd == p, "R1", "password", pwd, p);
        chk(nsel == 0, "R11", "sel_load on login", nsel, 0);
      end
      chk_wave(1'b1, 64, "R7");
    end else begin
      chk(arg_ok == 1'b0, freq, "arg_ok after bad stream", arg_ok, 0);
      chk(arg_ok == 1'b0 && nsel == 0, "R12", "no accept after refusal", nsel, 0);
      chk_wave(1'b0, 64, "R8");
    end
  endtask

  task automatic run_reset();
    @(posedge clk); #1;
    txn++; start = 1'b1; mode = 2'd2;
    @(posedge clk); #1;
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin   // stray bits during the pause
      bit_vld = 1'b1; bit_in = i[0];
      @(posedge clk); #1;
      bit_vld = 1'b0;
    end
    wait_done("R10");
    chk(rlen[0] >= 64 && rlen[0] <= 70, "R10", "quiet before ack", rlen[0], 64);
    chk(nrest == 1, "R10", "restore pulses", nrest, 1);
    chk(arg_ok == 1'b0, "R12", "arg_ok after reset op", arg_ok, 0);
    chk_wave(1'b1, 2112, "R10");
  endtask

  initial begin
    #(8 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk({done, mod_out, arg_ok, sel_load} == 4'b0000, "R12", "reset state",
        {done, mod_out, arg_ok, sel_load}, 0);

    // reserved mode
    @(posedge clk); #1;
    txn++; start = 1'b1; mode = 2'd3;
    @(posedge clk); #1; start = 1'b0;
    repeat (200) @(negedge clk);
    chk(ndone == 0 && rcnt == 0, "R13", "activity on reserved mode", ndone + rcnt, 0);

    // directed cases
    run_args(1'b0, 32'hDEADBEEF, 6'd0, 6'd0, 0, 0);
    run_args(1'b0, 32'h12345678, 6'd0, 6'd0, 1, 3);    // data bit, R2
    run_args(1'b0, 32'h12345678, 6'd0, 6'd0, 1, 17);   // parity bit, R2
    run_args(1'b0, 32'hA5A5_0F0F, 6'd0, 6'd0, 1, 40);  // column bit, R3
    run_args(1'b0, 32'hA5A5_0F0F, 6'd0, 6'd0, 1, 44);  // trailing zero, R4
    run_args(1'b1, 32'h0, 6'd5, 6'd33, 0, 0);
    run_args(1'b1, 32'h0, 6'd63, 6'd0, 2, 0);           // top bit set, R5
    run_args(1'b1, 32'h0, 6'd12, 6'd20, 1, 17);         // second parity, R5
    run_reset();
    run_args(1'b1, 32'h0, 6'd1, 6'd2, 0, 0);            // back to normal after reset

    // constrained random
    for (int it = 0; it < 30; it++) begin
      int  r    = $urandom_range(0, 9);
      int  kind = ($urandom_range(0, 1) == 1) ? 1 : 0;
      if (r == 0) run_reset();
      else if (r < 5) run_args(1'b1, 32'h0, 6'($urandom), 6'($urandom), kind, $urandom_range(0, 17));
      else run_args(1'b0, $urandom, 6'd0, 6'd0, kind, $urandom_range(0, 44));
    end

    summary();
    $finish;
  end

endmodule